// File: doc/BRIEF.md
# ADC Word Byte Output Formatter

This block sits behind a 16-bit converter and narrows each conversion result onto an 8-bit output bus. It runs on a fast system clock. It watches a slower ADC clock through a synchronizer and reacts to both edges of that clock. Each result passes through a fixed three-period pipeline.

On the rising ADC-clock edge the block shows the upper half of the result. In two-byte mode it follows with the lower half on the falling edge. In single-byte mode it keeps the upper half for the whole period. A phase flag tells the receiver which half is on the bus.

An active-low enable controls the bus. When the enable is high the bus is released: the bus-enable output stands in for a tri-state driver, and the data lines read zero. Results that never arrived, or that came in marked invalid, are shown as zero.

Top module: `adc_byte_fmt`

## Requirements
- R1: While reset is high, and after it falls until the first ADC-clock edge is seen, the internal byte is zero and the phase flag is 1.
- R2: `bus_en_o` equals the inverse of `oe_n_i` in every cycle. While `oe_n_i` is 1, `dout_o` reads zero. Releasing the bus does not disturb the held byte, which comes back unchanged when `oe_n_i` returns to 0.
- R3: A rising ADC-clock edge puts bits 15..8 of the output word on the bus and sets the phase flag to 1.
- R4: When `single_byte_i` is 0, a falling ADC-clock edge puts bits 7..0 of the same word on the bus and clears the phase flag to 0.
- R5: When `single_byte_i` is 1, a falling ADC-clock edge has no effect: the upper byte and the phase flag of 1 stay on the bus.
- R6: The word shown after rising edge k is the one sampled from `din_i` at rising edge k-3.
- R7: A pipeline slot that holds no sample, or that holds a sample taken while `din_vld_i` was 0, is shown as the word 0x0000.
- R8: The output changes on the third system-clock edge after the ADC-clock input changes: two edges for synchronization and one for the output register. Between detected edges the output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the ADC clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_clk_i | input | 1 | ADC clock, asynchronous to `clk` |
| din_i | input | 16 | Conversion result, sampled at rising ADC-clock edges |
| din_vld_i | input | 1 | Marks `din_i` as holding a real sample |
| single_byte_i | input | 1 | 1 selects upper-byte-only output; 0 selects two-byte output (default use) |
| oe_n_i | input | 1 | Output enable, active low |
| dout_o | output | 8 | Output byte bus, zero while released |
| bus_en_o | output | 1 | High while the bus is driven (tri-state control) |
| hi_phase_o | output | 1 | 1 while the upper byte is shown, 0 while the lower byte is shown |

## Verification
The first results sent are distinct valid words. Their upper and lower bytes differ, so a byte swap or a wrong latency count shows up as a wrong value. A run of invalid samples, and the empty start-up slots, separate zeroing from stale data. Periods in single-byte mode show whether a falling edge is really ignored. Periods with the enable released in the high half, the low half, or both show that releasing the bus only masks the lines and does not change the pipeline or the held byte.

// File: rtl/abf_pkg.sv
package abf_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } sample_t;

    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;

    function automatic logic [BYTE_W-1:0] upper_of(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] lower_of(input logic [WORD_W-1:0] w);
        return w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/abf_edge_sync.sv
module abf_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    generate
        for (genvar i = 0; i < CHAIN_W; i++) begin : g_chain
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= async_i;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

endmodule

// File: rtl/abf_pipe.sv
module abf_pipe
    import abf_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    adv_i,
    input  sample_t in_i,
    output sample_t tail_o
);
    sample_t stg_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst)        stg_q[i] <= '0;
                    else if (adv_i) stg_q[i] <= in_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst)        stg_q[i] <= '0;
                    else if (adv_i) stg_q[i] <= stg_q[i-1];
                end
            end
        end
    endgenerate

    assign tail_o = stg_q[DEPTH-1];

endmodule

// File: rtl/abf_byte_sel.sv
module abf_byte_sel
    import abf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              single_i,
    input  sample_t           tail_i,
    output logic [BYTE_W-1:0] byte_o,
    output half_e             half_o
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] next_word;
    logic [BYTE_W-1:0] byte_q;
    half_e             half_q;

    always_comb begin
        next_word = tail_i.vld ? tail_i.word : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            byte_q <= '0;
            half_q <= HALF_HIGH;
        end else if (rise_i) begin
            word_q <= next_word;
            byte_q <= upper_of(next_word);
            half_q <= HALF_HIGH;
        end else if (fall_i && !single_i) begin
            byte_q <= lower_of(word_q);
            half_q <= HALF_LOW;
        end
    end

    assign byte_o = byte_q;
    assign half_o = half_q;

endmodule

// File: rtl/adc_byte_fmt.sv
module adc_byte_fmt
    import abf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LATENCY     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_clk_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic              din_vld_i,
    input  logic              single_byte_i,
    input  logic              oe_n_i,
    output logic [BYTE_W-1:0] dout_o,
    output logic              bus_en_o,
    output logic              hi_phase_o
);
    logic              rise;
    logic              fall;
    sample_t           in_s;
    sample_t           tail;
    logic [BYTE_W-1:0] byte_q;
    half_e             half_q;

    abf_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (adc_clk_i),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign in_s.vld  = din_vld_i;
    assign in_s.word = din_i;

    abf_pipe #(.DEPTH(LATENCY)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (rise),
        .in_i   (in_s),
        .tail_o (tail)
    );

    abf_byte_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (rise),
        .fall_i   (fall),
        .single_i (single_byte_i),
        .tail_i   (tail),
        .byte_o   (byte_q),
        .half_o   (half_q)
    );

    assign bus_en_o   = ~oe_n_i;
    assign dout_o     = oe_n_i ? '0 : byte_q;
    assign hi_phase_o = (half_q == HALF_HIGH);

    assert_rise_high_R3: assert property (@(posedge clk) disable iff (rst)
        rise |=> hi_phase_o);

    assert_fall_low_R4: assert property (@(posedge clk) disable iff (rst)
        (fall && !single_byte_i) |=> !hi_phase_o);

    assert_single_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (fall && single_byte_i) |=> ($stable(byte_q) && $stable(hi_phase_o)));

    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rise && !tail.vld) |=> (byte_q == '0));

    assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!rise && !fall) |=> ($stable(byte_q) && $stable(hi_phase_o)));

    assert_one_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise, fall}));

endmodule

// File: tb/sim_adc_byte_fmt.sv
module sim_adc_byte_fmt;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adc_clk = 1'b0;
    logic [15:0] din = '0;
    logic        vld = 1'b0;
    logic        single = 1'b0;
    logic        oe_n = 1'b0;
    logic [7:0]  dout;
    logic        bus_en;
    logic        hi_phase;

    int          checks = 0;
    int          errors = 0;
    bit          chk_on = 1'b0;
    bit          done = 1'b0;
    string       cur = "R1";

    logic [7:0]  exp_byte = '0;
    logic        exp_phase = 1'b1;
    logic [15:0] exp_word = '0;
    logic [16:0] hist[$];

    adc_byte_fmt u0 (
        .clk           (clk),
        .rst           (rst),
        .adc_clk_i     (adc_clk),
        .din_i         (din),
        .din_vld_i     (vld),
        .single_byte_i (single),
        .oe_n_i        (oe_n),
        .dout_o        (dout),
        .bus_en_o      (bus_en),
        .hi_phase_o    (hi_phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
        end
    endtask

    // compare outputs against the reference model once per system clock, mid-cycle
    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic [7:0] ed;
            ed = oe_n ? 8'h00 : exp_byte;
            chk(bus_en == !oe_n, "R2", "bus_en", bus_en, !oe_n);
            chk(dout == ed, cur, "dout", dout, ed);
            chk(hi_phase == exp_phase, cur, "phase", hi_phase, exp_phase);
        end
    end

    // one ADC period; model: rise k shows sample of rise k-3, after 3 system edges (R8)
    task automatic adc_period(input logic [15:0] w, input logic v, input logic m,
                              input logic oe_hi, input logic oe_lo, input string tag);
        logic [16:0] e;
        @(posedge clk); #1;
        din = w; vld = v; single = m; oe_n = oe_hi; cur = tag; adc_clk = 1'b1;
        hist.push_back({v, w});
        repeat (3) @(posedge clk); #1;
        if (hist.size() >= 4) begin
            e = hist[hist.size()-4];
            exp_word = e[16] ? e[15:0] : 16'h0000;
        end else begin
            exp_word = 16'h0000;
        end
        exp_byte  = exp_word[15:8];
        exp_phase = 1'b1;
        repeat (HALF-3) @(posedge clk); #1;
        adc_clk = 1'b0; oe_n = oe_lo;
        repeat (3) @(posedge clk); #1;
        if (!m) begin
            exp_byte  = exp_word[7:0];
            exp_phase = 1'b0;
        end
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'hA5C3 ^ (16'(i) * 16'h1357);
    endfunction

    initial begin
        // R1: reset state
        @(posedge clk); #1;
        chk_on = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (3) @(posedge clk);
        // R7: first three rises find empty slots
        for (int i = 0; i < 3; i++) adc_period(pat(i), 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        // R6: valid words appear three periods later
        for (int i = 3; i < 7; i++) adc_period(pat(i), 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        // R7: invalid samples become zero
        adc_period(16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        adc_period(16'hBEEF, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        // R3: upper byte on rising edge
        for (int i = 7; i < 10; i++) adc_period(pat(i), 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        // R5: single-byte mode ignores falling edges
        for (int i = 10; i < 15; i++) adc_period(pat(i), 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        // R2: bus released in various halves
        adc_period(pat(15), 1'b1, 1'b0, 1'b1, 1'b1, "R2");
        adc_period(pat(16), 1'b1, 1'b0, 1'b1, 1'b0, "R2");
        adc_period(pat(17), 1'b1, 1'b0, 1'b0, 1'b1, "R2");
        adc_period(pat(18), 1'b1, 1'b1, 1'b1, 1'b1, "R2");
        // R4: back to two-byte output
        for (int i = 19; i < 23; i++) adc_period(pat(i), 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        // R8: output timing relative to the ADC clock
        for (int i = 23; i < 27; i++) adc_period(pat(i), 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule